// File: doc/BRIEF.md
# Grouped Magnitude Comparator

This block compares two unsigned operands of equal width and raises exactly one of three flags: operands equal, first operand smaller, or first operand larger. The decision is set by the most significant bit position at which the two operands differ. At that position, the operand that carries a 1 is the larger one.

The operand width is a parameter and must be a multiple of four. The datapath is split into four-bit slices. Each slice marks its matching and mismatching bit pairs. It extends an equality chain that runs from the top slice down to the bottom slice. It also forms gated per-bit "first operand wins here" terms. A two-gate resolver turns the overall equality and the combined win term into the smaller and larger flags. An optional output register holds the three flags and is cleared by a synchronous reset.

Top module: `grp_mag_cmp`

## Requirements
- R1: `eq_o` is 1 exactly when `a_i` equals `b_i`.
- R2: `gt_o` is 1 exactly when `a_i` holds a 1 at the most significant bit position (bit N-1 is the MSB) where the operands differ.
- R3: `lt_o` is 1 exactly when `b_i` holds a 1 at the most significant bit position where the operands differ.
- R4: Outside reset and after the first registered result, exactly one of `eq_o`, `lt_o`, `gt_o` is 1.
- R5: The result is correct for every operand pair at widths 4 and 8. This covers a first difference in any slice, including the bit just below a slice boundary.
- R6: With `REG_OUT=1`, the flags for operands present at a rising clock edge appear right after that edge, which is one cycle of latency. With `REG_OUT=0`, the flags follow the operands combinationally.
- R7: With `REG_OUT=1`, a rising edge with `rst` high clears all three flags to 0, whatever the operands are.
- R8: For the 4-bit operands a=1100 and b=1010, the flags are eq=0, lt=0, gt=1.
- R9: When all bits above position k are equal, a single-bit difference at position k alone decides the result. This holds for k = 0 (LSB) and k = N-1 (MSB).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional flag register |
| rst | input | 1 | Synchronous active-high reset of the flag register |
| a_i | input | N | First unsigned operand |
| b_i | input | N | Second unsigned operand |
| eq_o | output | 1 | Operands are equal |
| lt_o | output | 1 | First operand is smaller |
| gt_o | output | 1 | First operand is larger |

## Verification
The hardest case to reach is a first difference deep in the lowest slice of a wide operand. That case needs every higher bit to match, and uniformly random 64-bit pairs almost never produce it. The stimulus therefore copies one operand into the other and flips a single chosen bit, in the LSB, at slice boundaries, in the MSB and at random positions. The equality chain must then carry through every slice before the gated win term can decide. At widths 4 and 8 the operand space is swept exhaustively.

// File: rtl/grp_mag_cmp_pkg.sv
`timescale 1ns/1ps
package grp_mag_cmp_pkg;
  localparam int unsigned SLICE_W = 4;

  typedef struct packed {
    logic eq;
    logic lt;
    logic gt;
  } cmp_flags_t;

  localparam cmp_flags_t FLAGS_CLEAR = '{eq: 1'b0, lt: 1'b0, gt: 1'b0};
endpackage

// File: rtl/grp_mag_cmp_slice.sv
`timescale 1ns/1ps
module grp_mag_cmp_slice
  import grp_mag_cmp_pkg::*;
#(
  parameter int unsigned W = SLICE_W
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         eq_in,
  output logic         eq_out,
  output logic         win_out
);
  logic [W-1:0] diff;
  logic [W-1:0] same;
  logic [W:0]   pfx;
  logic [W-1:0] win_n;

  assign diff   = a_i ^ b_i;
  assign same   = ~(a_i ^ b_i);
  assign pfx[W] = eq_in;

  for (genvar i = W - 1; i >= 0; i--) begin : g_bit
    // equality of every bit above i, gated by the incoming chain
    assign pfx[i]   = pfx[i+1] & same[i];
    // inverted term: this bit is the first mismatch and a holds the 1
    assign win_n[i] = ~(diff[i] & pfx[i+1] & a_i[i]);
  end

  assign eq_out  = pfx[0];
  assign win_out = ~(&win_n);
endmodule

// File: rtl/grp_mag_cmp_resolve.sv
`timescale 1ns/1ps
module grp_mag_cmp_resolve
  import grp_mag_cmp_pkg::*;
(
  input  logic       eq_i,
  input  logic       win_i,
  output cmp_flags_t flags_o
);
  logic lt_n;
  logic gt_n;

  assign lt_n = ~(eq_i | win_i);
  assign gt_n = ~(lt_n | eq_i);

  assign flags_o.eq = eq_i;
  assign flags_o.lt = lt_n;
  assign flags_o.gt = gt_n;
endmodule

// File: rtl/grp_mag_cmp_stage.sv
`timescale 1ns/1ps
module grp_mag_cmp_stage
  import grp_mag_cmp_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic       clk,
  input  logic       rst,
  input  cmp_flags_t d_i,
  output cmp_flags_t q_o
);
  if (REG_OUT) begin : g_reg
    cmp_flags_t q_r;
    always_ff @(posedge clk) begin
      if (rst) q_r <= FLAGS_CLEAR;
      else     q_r <= d_i;
    end
    assign q_o = q_r;
  end else begin : g_pass
    assign q_o = d_i;
  end
endmodule

// File: rtl/grp_mag_cmp.sv
`timescale 1ns/1ps
module grp_mag_cmp
  import grp_mag_cmp_pkg::*;
#(
  parameter int unsigned N       = 64,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] a_i,
  input  logic [N-1:0] b_i,
  output logic         eq_o,
  output logic         lt_o,
  output logic         gt_o
);
  localparam int unsigned SLICES = N / SLICE_W;

  if (N < SLICE_W || (N % SLICE_W) != 0) begin : g_bad_width
    $error("grp_mag_cmp: N must be a nonzero multiple of 4");
  end

  logic [SLICES:0]   eq_chain;
  logic [SLICES-1:0] win_slice;
  logic              win_any;
  cmp_flags_t        flags_c;
  cmp_flags_t        flags_q;

  assign eq_chain[SLICES] = 1'b1;

  for (genvar s = SLICES - 1; s >= 0; s--) begin : g_slice
    grp_mag_cmp_slice #(.W(SLICE_W)) u_slice (
      .a_i    (a_i[s*SLICE_W +: SLICE_W]),
      .b_i    (b_i[s*SLICE_W +: SLICE_W]),
      .eq_in  (eq_chain[s+1]),
      .eq_out (eq_chain[s]),
      .win_out(win_slice[s])
    );
  end

  assign win_any = |win_slice;

  grp_mag_cmp_resolve u_resolve (
    .eq_i   (eq_chain[0]),
    .win_i  (win_any),
    .flags_o(flags_c)
  );

  grp_mag_cmp_stage #(.REG_OUT(REG_OUT)) u_stage (
    .clk(clk),
    .rst(rst),
    .d_i(flags_c),
    .q_o(flags_q)
  );

  assign eq_o = flags_q.eq;
  assign lt_o = flags_q.lt;
  assign gt_o = flags_q.gt;
endmodule

// File: rtl/grp_mag_cmp_chk.sv
`timescale 1ns/1ps
module grp_mag_cmp_chk #(
  parameter int unsigned N       = 64,
  parameter bit          REG_OUT = 1'b1
) (
  input logic         clk,
  input logic         rst,
  input logic [N-1:0] a_i,
  input logic [N-1:0] b_i,
  input logic         eq_o,
  input logic         lt_o,
  input logic         gt_o
);
  logic seen_q;
  always_ff @(posedge clk) begin
    if (rst) seen_q <= 1'b0;
    else     seen_q <= 1'b1;
  end

  if (REG_OUT) begin : g_reg
    assert_eq_match_R1: assert property (@(posedge clk) disable iff (rst)
      (a_i == b_i) |=> eq_o);
    assert_gt_match_R2: assert property (@(posedge clk) disable iff (rst)
      (a_i > b_i) |=> gt_o);
    assert_lt_match_R3: assert property (@(posedge clk) disable iff (rst)
      (a_i < b_i) |=> lt_o);
    assert_one_flag_R4: assert property (@(posedge clk) disable iff (rst)
      seen_q |-> ($countones({eq_o, lt_o, gt_o}) == 1));
    assert_reset_clear_R7: assert property (@(posedge clk)
      rst |=> ({eq_o, lt_o, gt_o} == 3'b000));
  end else begin : g_comb
    assert_eq_match_R1: assert property (@(posedge clk) disable iff (rst)
      (a_i == b_i) |-> eq_o);
    assert_gt_match_R2: assert property (@(posedge clk) disable iff (rst)
      (a_i > b_i) |-> gt_o);
    assert_lt_match_R3: assert property (@(posedge clk) disable iff (rst)
      (a_i < b_i) |-> lt_o);
    assert_one_flag_R4: assert property (@(posedge clk) disable iff (rst)
      ($countones({eq_o, lt_o, gt_o}) == 1));
  end
endmodule

bind grp_mag_cmp grp_mag_cmp_chk #(.N(N), .REG_OUT(REG_OUT)) u_chk (
  .clk (clk),
  .rst (rst),
  .a_i (a_i),
  .b_i (b_i),
  .eq_o(eq_o),
  .lt_o(lt_o),
  .gt_o(gt_o)
);

// File: tb/test_grp_mag_cmp.sv
`timescale 1ns/1ps
module test_grp_mag_cmp;
  localparam int unsigned NW = 64;
  localparam int unsigned WATCHDOG_CYC = 150000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;  // 50 MHz

  logic [NW-1:0] a64 = '0, b64 = '0;
  logic          eq64, lt64, gt64;
  logic [3:0]    a4 = '0, b4 = '0;
  logic          eq4, lt4, gt4;
  logic [7:0]    a8 = '0, b8 = '0;
  logic          eq8, lt8, gt8;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  grp_mag_cmp #(.N(NW), .REG_OUT(1'b1)) i_grp_mag_cmp (
    .clk(clk), .rst(rst), .a_i(a64), .b_i(b64),
    .eq_o(eq64), .lt_o(lt64), .gt_o(gt64));
  grp_mag_cmp #(.N(4), .REG_OUT(1'b0)) i_w4 (
    .clk(clk), .rst(rst), .a_i(a4), .b_i(b4),
    .eq_o(eq4), .lt_o(lt4), .gt_o(gt4));
  grp_mag_cmp #(.N(8), .REG_OUT(1'b0)) i_w8 (
    .clk(clk), .rst(rst), .a_i(a8), .b_i(b8),
    .eq_o(eq8), .lt_o(lt8), .gt_o(gt8));

  typedef struct {
    logic [2:0] flags;  // {eq, lt, gt}
    string      req;
  } sb_item_t;
  sb_item_t sb[$];

  function automatic logic [2:0] model(input logic [NW-1:0] a, input logic [NW-1:0] b);
    return {a == b, a < b, a > b};
  endfunction

  task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: flags{eq,lt,gt} actual=%b expected=%b", req, act, exp);
    end
  endtask

  // driver: operands change at the falling edge; the expectation is queued
  task automatic drive(input logic [NW-1:0] a, input logic [NW-1:0] b, input string req);
    sb_item_t it;
    @(negedge clk);
    a64 = a;
    b64 = b;
    it.flags = model(a, b);
    it.req   = req;
    sb.push_back(it);
  endtask

  // monitor: registered result is stable 5 ns after the capturing edge (R6)
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (sb.size() != 0) begin
        sb_item_t it;
        it = sb.pop_front();
        check(it.req, {eq64, lt64, gt64}, it.flags);
        checks++;
        if ($countones({eq64, lt64, gt64}) != 1) begin
          errors++;
          $display("FAIL R4: flags{eq,lt,gt} actual=%b expected one-hot", {eq64, lt64, gt64});
        end
      end
    end
  end

  task automatic drain();
    while (sb.size() != 0) @(posedge clk);
    @(posedge clk);
    #6;
  endtask

  initial begin
    // R7: reset clears the flags
    repeat (3) @(posedge clk);
    #5;
    check("R7 reset state", {eq64, lt64, gt64}, 3'b000);
    @(negedge clk);
    rst = 1'b0;

    // R1/R2/R3 corners and R6 latency via the scoreboard
    drive('0, '0, "R1 zeros");
    drive('1, '1, "R1 ones");
    drive(64'h1, 64'h0, "R9 LSB a>b");
    drive(64'h0, 64'h1, "R9 LSB a<b");
    drive(64'h8000_0000_0000_0000, 64'h0, "R9 MSB a>b");
    drive(64'h7FFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000, "R9 MSB a<b");
    drive(64'h10, 64'h0F, "R2 slice boundary");
    drive(64'h0F, 64'h10, "R3 slice boundary");
    drive(64'hDEAD_BEEF_0000_0000, 64'hDEAD_BEEF_0000_0000, "R1 pattern");
    for (int k = 0; k < NW; k++) begin
      logic [NW-1:0] base;
      base = {$urandom, $urandom};
      drive(base, base ^ (64'h1 << k), "R9 single-bit flip");
    end
    for (int k = 0; k < 200; k++) begin
      drive({$urandom, $urandom}, {$urandom, $urandom}, "R2/R3 random");
    end
    for (int k = 0; k < 40; k++) begin
      logic [NW-1:0] r;
      r = {$urandom, $urandom};
      drive(r, r, "R1 random equal");
    end
    drain();

    // R7: mid-run reset overrides a>b operands
    @(negedge clk);
    a64 = 64'h5; b64 = 64'h3; rst = 1'b1;
    @(posedge clk); #5;
    check("R7 reset overrides operands", {eq64, lt64, gt64}, 3'b000);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk); #5;
    check("R6 first result after reset", {eq64, lt64, gt64}, 3'b001);

    // R8 worked example on the 4-bit instance
    @(negedge clk);
    a4 = 4'b1100; b4 = 4'b1010;
    #5;
    check("R8 example", {eq4, lt4, gt4}, 3'b001);

    // R5 exhaustive sweep at width 4
    for (int i = 0; i < 16; i++) begin
      for (int j = 0; j < 16; j++) begin
        @(negedge clk);
        a4 = 4'(i); b4 = 4'(j);
        #5;
        check("R5 width4", {eq4, lt4, gt4}, {i == j, i < j, i > j});
      end
    end
    // R5 exhaustive sweep at width 8
    for (int i = 0; i < 256; i++) begin
      for (int j = 0; j < 256; j++) begin
        @(negedge clk);
        a8 = 8'(i); b8 = 8'(j);
        #5;
        check("R5 width8", {eq8, lt8, gt8}, {i == j, i < j, i > j});
      end
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYC) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule